// File: doc/BRIEF.md
# Size-Aware Condition Code Unit

This block holds the eight-bit condition code register of a processor core whose arithmetic works on byte, word and long operands. When an arithmetic operation is presented (add, add with extend, subtract, subtract with extend, compare or negate), the block forms the result in the same cycle. It masks that result to the selected operand size. On the next clock edge it loads the half-carry, negative, zero, overflow and carry flags derived at that size. The half-carry tap follows the operand size: it sits four bits below the top bit of the operand.

Software reaches the register through a load with an eight-bit immediate and through AND, OR and XOR with an immediate. A store is a read of the register output. Exception entry forces the interrupt mask bit to one. The mask bit drives an output that the interrupt controller uses to hold off maskable requests. Non-maskable requests do not pass through this gate. Two register bits are free for software use, and arithmetic never changes them.

Top module: `ccr_unit`

## Requirements
- R1: While reset is sampled high, the register becomes 0x80 on the next edge. That value has the mask bit set and every other bit cleared.
- R2: `int_mask` always equals bit 7 of the register. Bit layout from bit 7 down to bit 0: mask, user-A, H, user-B, N, Z, V, C.
- R3: `result` is the arithmetic result masked to the operand size, with all bits above that size zero. Size code 0 is byte, 1 is word, and 2 or 3 is long. Op code 0 is add and 1 is add with extend (adds `carry_in`). Op code 2 is subtract and 3 is subtract with extend (also subtracts `carry_in`). Op code 4 is compare (A minus B). Op code 5 is negate (0 minus B, with A ignored).
- R4: `result_we` is high for a valid arithmetic operation, except for compare, which updates flags only.
- R5: One edge after an arithmetic operation, H holds the carry (for adds) or borrow (for subtracts, compare and negate) out of bit 3, 11 or 27 for byte, word or long size.
- R6: One edge after an arithmetic operation, C holds the carry out of, or borrow into, the top bit at the active size.
- R7: One edge after an arithmetic operation, N holds the top bit of the size-masked result and Z is one exactly when that result is zero.
- R8: One edge after an arithmetic operation, V is one exactly when the signed result at the active size overflows.
- R9: Arithmetic updates never change bit 7, bit 6 or bit 4.
- R10: Register op code 1 loads the immediate, 2 ANDs it in, 3 ORs it in and 4 XORs it in. Each takes effect one edge later. When a register op is present, any arithmetic request in that cycle is ignored.
- R11: Exception entry sets bit 7 on the next edge, overriding a simultaneous register op that would clear it. The other bits follow that register op.
- R12: With no arithmetic, no register op and no exception entry, the register holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| arith_valid | input | 1 | Arithmetic operation present this cycle |
| arith_op | input | 3 | Arithmetic op code (see R3) |
| op_size | input | 2 | Operand size code (see R3) |
| opnd_a | input | 32 | First operand (minuend / augend) |
| opnd_b | input | 32 | Second operand (subtrahend / addend / negate source) |
| carry_in | input | 1 | Extend carry/borrow for the extend variants |
| result | output | 32 | Size-masked arithmetic result |
| result_we | output | 1 | Result should be written back |
| reg_op | input | 3 | Register op code (see R10), 0 = none |
| reg_imm | input | 8 | Immediate for register ops |
| exc_entry | input | 1 | Exception-handling sequence starts |
| ccr_q | output | 8 | Register contents (store path) |
| int_mask | output | 1 | Masks maskable interrupts when high |

## Verification
On every cycle, the assertions check the following. Reset leaves 0x80. Exception entry always leaves the mask bit set. Arithmetic leaves the mask and user bits untouched. An idle cycle holds the register. The registered Z flag agrees with the zero test of the result seen one cycle earlier. The arithmetic flags depend on the full carry and overflow behaviour at each size, so only the bench scenarios can show them correct. These scenarios cover the half-carry tap moving between bits 3, 11 and 27, borrow in the extend subtract, and negate of the most negative value. The bench also drives a long random run against a behavioural model.

// File: rtl/ccu_pkg.sv
package ccu_pkg;

    localparam int DATA_W    = 32;
    localparam int BYTE_W    = 8;
    localparam int NUM_SIZES = 3;
    localparam int NIB_W     = 4;
    localparam int CCR_W     = 8;

    // Bit positions inside the register
    localparam int BIT_MASK  = 7;
    localparam int BIT_USRA  = 6;
    localparam int BIT_H     = 5;
    localparam int BIT_USRB  = 4;
    localparam int BIT_N     = 3;
    localparam int BIT_Z     = 2;
    localparam int BIT_V     = 1;
    localparam int BIT_C     = 0;

    localparam logic [CCR_W-1:0] CCR_RESET = 8'h80;

    typedef enum logic [2:0] {
        AOP_ADD  = 3'd0,
        AOP_ADDX = 3'd1,
        AOP_SUB  = 3'd2,
        AOP_SUBX = 3'd3,
        AOP_CMP  = 3'd4,
        AOP_NEG  = 3'd5
    } arith_op_e;

    typedef enum logic [2:0] {
        ROP_NONE = 3'd0,
        ROP_LOAD = 3'd1,
        ROP_AND  = 3'd2,
        ROP_OR   = 3'd3,
        ROP_XOR  = 3'd4
    } reg_op_e;

    typedef struct packed {
        logic h;
        logic n;
        logic z;
        logic v;
        logic c;
    } flags_t;

    // Subtract-class operations feed the adder with an inverted B operand
    function automatic logic op_is_sub(input arith_op_e op);
        return (op == AOP_SUB) || (op == AOP_SUBX) ||
               (op == AOP_CMP) || (op == AOP_NEG);
    endfunction

    // Size code 3 is folded onto long
    function automatic logic [1:0] size_index(input logic [1:0] code);
        return (code == 2'd3) ? 2'd2 : code;
    endfunction

endpackage

// File: rtl/ccu_adder.sv
module ccu_adder #(
    parameter int W     = 8,
    parameter int TAP_W = 4
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         ci,
    output logic [W-1:0] sum,
    output logic         co,
    output logic         hc,
    output logic         ov
);
    localparam int LOW_W = W - TAP_W;

    logic [W:0]     full;
    logic [LOW_W:0] low;

    always_comb begin
        full = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, ci};
        low  = {1'b0, a[LOW_W-1:0]} + {1'b0, b[LOW_W-1:0]} + {{LOW_W{1'b0}}, ci};
        sum  = full[W-1:0];
        co   = full[W];
        hc   = low[LOW_W];
        ov   = (a[W-1] == b[W-1]) && (full[W-1] != a[W-1]);
    end
endmodule

// File: rtl/ccu_flag_sel.sv
module ccu_flag_sel
    import ccu_pkg::*;
(
    input  logic [DATA_W-1:0]    sum_sel,
    input  logic                 co,
    input  logic                 hc,
    input  logic                 ov,
    input  logic                 is_sub,
    input  logic [1:0]           size_idx,
    output flags_t               flags
);
    logic top_bit;

    always_comb begin
        unique case (size_idx)
            2'd0:    top_bit = sum_sel[BYTE_W-1];
            2'd1:    top_bit = sum_sel[2*BYTE_W-1];
            default: top_bit = sum_sel[DATA_W-1];
        endcase
        // Subtracts run as A + ~B + 1, so borrow is the inverted carry
        flags.c = is_sub ? ~co : co;
        flags.h = is_sub ? ~hc : hc;
        flags.v = ov;
        flags.n = top_bit;
        flags.z = (sum_sel == '0);
    end
endmodule

// File: rtl/ccu_ccr_reg.sv
module ccu_ccr_reg
    import ccu_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             flag_we,
    input  flags_t           flags,
    input  reg_op_e          rop,
    input  logic [CCR_W-1:0] imm,
    input  logic             exc_entry,
    output logic [CCR_W-1:0] ccr_q
);
    logic [CCR_W-1:0] ccr_d;

    always_comb begin
        ccr_d = ccr_q;
        unique case (rop)
            ROP_LOAD: ccr_d = imm;
            ROP_AND:  ccr_d = ccr_q & imm;
            ROP_OR:   ccr_d = ccr_q | imm;
            ROP_XOR:  ccr_d = ccr_q ^ imm;
            default: begin
                if (flag_we) begin
                    ccr_d[BIT_H] = flags.h;
                    ccr_d[BIT_N] = flags.n;
                    ccr_d[BIT_Z] = flags.z;
                    ccr_d[BIT_V] = flags.v;
                    ccr_d[BIT_C] = flags.c;
                end
            end
        endcase
        if (exc_entry) ccr_d[BIT_MASK] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) ccr_q <= CCR_RESET;
        else     ccr_q <= ccr_d;
    end

    assert_reset_value_R1: assert property (@(posedge clk)
        rst |=> (ccr_q == CCR_RESET));

    assert_exc_sets_mask_R11: assert property (@(posedge clk) disable iff (rst)
        exc_entry |=> ccr_q[BIT_MASK]);

    assert_arith_keeps_user_R9: assert property (@(posedge clk) disable iff (rst)
        (flag_we && rop == ROP_NONE && !exc_entry) |=>
        ($stable(ccr_q[BIT_MASK]) && $stable(ccr_q[BIT_USRA]) && $stable(ccr_q[BIT_USRB])));

    assert_idle_hold_R12: assert property (@(posedge clk) disable iff (rst)
        (!flag_we && rop == ROP_NONE && !exc_entry) |=> $stable(ccr_q));
endmodule

// File: rtl/ccr_unit.sv
module ccr_unit
    import ccu_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              arith_valid,
    input  logic [2:0]        arith_op,
    input  logic [1:0]        op_size,
    input  logic [31:0]       opnd_a,
    input  logic [31:0]       opnd_b,
    input  logic              carry_in,
    output logic [31:0]       result,
    output logic              result_we,
    input  logic [2:0]        reg_op,
    input  logic [7:0]        reg_imm,
    input  logic              exc_entry,
    output logic [7:0]        ccr_q,
    output logic              int_mask
);
    arith_op_e aop;
    reg_op_e   rop;
    logic      is_sub;
    logic      ci;
    logic [1:0] sz_idx;
    logic [DATA_W-1:0] a_eff;
    logic [DATA_W-1:0] b_eff;

    logic [DATA_W-1:0]    sum_v [NUM_SIZES];
    logic [NUM_SIZES-1:0] co_v;
    logic [NUM_SIZES-1:0] hc_v;
    logic [NUM_SIZES-1:0] ov_v;
    flags_t               flags;

    always_comb begin
        aop    = arith_op_e'(arith_op);
        rop    = reg_op_e'(reg_op);
        is_sub = op_is_sub(aop);
        sz_idx = size_index(op_size);
        a_eff  = (aop == AOP_NEG) ? '0 : opnd_a;
        b_eff  = is_sub ? ~opnd_b : opnd_b;
        unique case (aop)
            AOP_ADDX: ci = carry_in;
            AOP_SUBX: ci = ~carry_in;
            default:  ci = is_sub;
        endcase
    end

    for (genvar g = 0; g < NUM_SIZES; g++) begin : g_size
        localparam int W = BYTE_W << g;
        logic [W-1:0] sum_w;

        ccu_adder #(.W(W), .TAP_W(NIB_W)) i_adder (
            .a   (a_eff[W-1:0]),
            .b   (b_eff[W-1:0]),
            .ci  (ci),
            .sum (sum_w),
            .co  (co_v[g]),
            .hc  (hc_v[g]),
            .ov  (ov_v[g])
        );
        assign sum_v[g] = DATA_W'(sum_w);
    end

    assign result    = sum_v[sz_idx];
    assign result_we = arith_valid && (aop != AOP_CMP);

    ccu_flag_sel i_flag_sel (
        .sum_sel  (result),
        .co       (co_v[sz_idx]),
        .hc       (hc_v[sz_idx]),
        .ov       (ov_v[sz_idx]),
        .is_sub   (is_sub),
        .size_idx (sz_idx),
        .flags    (flags)
    );

    ccu_ccr_reg i_ccr_reg (
        .clk       (clk),
        .rst       (rst),
        .flag_we   (arith_valid),
        .flags     (flags),
        .rop       (rop),
        .imm       (reg_imm),
        .exc_entry (exc_entry),
        .ccr_q     (ccr_q)
    );

    assign int_mask = ccr_q[BIT_MASK];

    assert_zero_flag_R7: assert property (@(posedge clk) disable iff (rst)
        (arith_valid && rop == ROP_NONE) |=> (ccr_q[BIT_Z] == ($past(result) == '0)));

    assert_mask_follows_R2: assert property (@(posedge clk) disable iff (rst)
        exc_entry |=> int_mask);
endmodule

// File: tb/test_ccr_unit.sv
module test_ccr_unit;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        arith_valid = 1'b0;
    logic [2:0]  arith_op = '0;
    logic [1:0]  op_size = '0;
    logic [31:0] opnd_a = '0;
    logic [31:0] opnd_b = '0;
    logic        carry_in = 1'b0;
    logic [31:0] result;
    logic        result_we;
    logic [2:0]  reg_op = '0;
    logic [7:0]  reg_imm = '0;
    logic        exc_entry = 1'b0;
    logic [7:0]  ccr_q;
    logic        int_mask;

    int checks = 0;
    int errors = 0;
    logic [7:0] exp_ccr;

    always #2 clk = ~clk;

    ccr_unit i_ccr_unit (
        .clk, .rst, .arith_valid, .arith_op, .op_size, .opnd_a, .opnd_b,
        .carry_in, .result, .result_we, .reg_op, .reg_imm, .exc_entry,
        .ccr_q, .int_mask
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Behavioural model: returns {h,n,z,v,c} and the masked result
    task automatic model(input int op, input int sz, input longint unsigned a_in,
                         input longint unsigned b_in, input bit cin,
                         output longint unsigned res, output bit [4:0] fl);
        int w;
        longint unsigned mask, hm, a, b, full;
        longint sa, sb, sr, half;
        bit add_t, h, n, z, v, c;
        int x;
        w    = (sz >= 2) ? 32 : (8 << sz);
        mask = (64'd1 << w) - 1;
        hm   = (64'd1 << (w - 4)) - 1;
        half = longint'(64'd1 << (w - 1));
        a    = (op == 5) ? 0 : (a_in & mask);
        b    = b_in & mask;
        add_t = (op == 0) || (op == 1);
        x    = ((op == 1) || (op == 3)) ? int'(cin) : 0;
        sa   = (longint'(a) >= half) ? longint'(a) - 2*half : longint'(a);
        sb   = (longint'(b) >= half) ? longint'(b) - 2*half : longint'(b);
        if (add_t) begin
            full = a + b + x;
            c = full[w];
            h = (((a & hm) + (b & hm) + x) >> (w - 4)) != 0;
            sr = sa + sb + x;
        end else begin
            full = a - b - x;
            c = a < (b + x);
            h = (a & hm) < ((b & hm) + x);
            sr = sa - sb - x;
        end
        res = full & mask;
        n = res[w-1];
        z = (res == 0);
        v = (sr >= half) || (sr < -half);
        fl = {h, n, z, v, c};
    endtask

    task automatic cycle(input bit av, input int op, input int sz,
                         input logic [31:0] a, input logic [31:0] b, input bit cin,
                         input int rop, input logic [7:0] imm, input bit exc,
                         input string tag);
        longint unsigned res;
        bit [4:0] fl;
        @(negedge clk);
        arith_valid = av; arith_op = op[2:0]; op_size = sz[1:0];
        opnd_a = a; opnd_b = b; carry_in = cin;
        reg_op = rop[2:0]; reg_imm = imm; exc_entry = exc;
        #1;
        model(op, sz, a, b, cin, res, fl);
        if (av) begin
            check({tag, " R3 result"}, result, res[31:0]);
            check({tag, " R4 write enable"}, {31'b0, result_we}, {31'b0, op != 4});
        end
        case (rop)
            1: exp_ccr = imm;
            2: exp_ccr = exp_ccr & imm;
            3: exp_ccr = exp_ccr | imm;
            4: exp_ccr = exp_ccr ^ imm;
            default: if (av) begin
                exp_ccr[5] = fl[4]; exp_ccr[3] = fl[3]; exp_ccr[2] = fl[2];
                exp_ccr[1] = fl[1]; exp_ccr[0] = fl[0];
            end
        endcase
        if (exc) exp_ccr[7] = 1'b1;
        @(posedge clk); #1;
        check({tag, " register"}, {24'b0, ccr_q}, {24'b0, exp_ccr});
        check({tag, " R2 mask"}, {31'b0, int_mask}, {31'b0, exp_ccr[7]});
    endtask

    initial begin
        #(4 * 200000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (2) @(posedge clk);
        #1;
        check("R1 reset value", {24'b0, ccr_q}, 32'h80);
        check("R2 mask after reset", {31'b0, int_mask}, 32'd1);
        @(negedge clk); rst = 1'b0;
        exp_ccr = 8'h80;

        // R10 register operations
        cycle(0, 0, 0, 0, 0, 0, 1, 8'h50, 0, "R10 load");
        cycle(0, 0, 0, 0, 0, 0, 3, 8'h0F, 0, "R10 or");
        cycle(0, 0, 0, 0, 0, 0, 2, 8'hF3, 0, "R10 and");
        cycle(0, 0, 0, 0, 0, 0, 4, 8'hFF, 0, "R10 xor");
        cycle(0, 0, 0, 0, 0, 0, 0, 8'h00, 0, "R12 idle hold");
        // R10 register op beats arithmetic in the same cycle
        cycle(1, 0, 0, 32'hFF, 32'h01, 0, 1, 8'h40, 0, "R10 op beats arith");
        // R11 exception wins over clearing AND
        cycle(0, 0, 0, 0, 0, 0, 2, 8'h00, 1, "R11 exc vs and");
        cycle(0, 0, 0, 0, 0, 0, 1, 8'h50, 0, "R9 setup users");
        // R5 half carry at byte/word/long
        cycle(1, 0, 0, 32'hFFFF_FF0F, 32'h01, 0, 0, 0, 0, "R5 byte H R9");
        cycle(1, 0, 1, 32'h0FFF, 32'h0001, 0, 0, 0, 0, "R5 word H");
        cycle(1, 0, 2, 32'h0FFF_FFFF, 32'h1, 0, 0, 0, 0, "R5 long H");
        // R6 carry and R7 zero
        cycle(1, 0, 0, 32'hFF, 32'h01, 0, 0, 0, 0, "R6 R7 byte wrap");
        cycle(1, 2, 1, 32'h0001, 32'h0002, 0, 0, 0, 0, "R6 word borrow");
        cycle(1, 3, 0, 32'h10, 32'h0F, 1, 0, 0, 0, "R6 R7 subx zero");
        // R8 overflow and negate of most negative
        cycle(1, 5, 0, 32'h55, 32'h80, 0, 0, 0, 0, "R8 neg 0x80");
        cycle(1, 0, 2, 32'h7FFF_FFFF, 32'h1, 0, 0, 0, 0, "R8 long add ovf");
        cycle(1, 4, 1, 32'h8000, 32'h0001, 0, 0, 0, 0, "R4 R8 compare");
        cycle(1, 1, 3, 32'hFFFF_FFFF, 32'h0, 1, 0, 0, 0, "R3 addx size3");
        cycle(0, 0, 0, 0, 0, 0, 0, 0, 1, "R11 exc alone");

        for (int i = 0; i < 600; i++) begin
            int op, rop;
            bit av;
            op  = $urandom_range(0, 5);
            rop = ($urandom_range(0, 7) == 0) ? $urandom_range(1, 4) : 0;
            av  = ($urandom_range(0, 5) != 0);
            cycle(av, op, $urandom_range(0, 3), $urandom, $urandom, 1'($urandom),
                  rop, 8'($urandom), ($urandom_range(0, 15) == 0), "R5 R6 R7 R8 random");
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule